// File: doc/BRIEF.md
# Audio DAC Power-Up Sequencer

This block runs the start-up of a stereo audio converter once its reset is released. It watches the left/right frame clock, passes it through a two-flop synchronizer into the master-clock domain and counts its rising edges as frames. After reset it gives software a window of frames to write a control-port enable strobe. The window is longer at higher sample-rate speed modes. If the strobe arrives inside the window, the block enters control-port operation and holds the converter powered down until the software power-down bit is cleared. If the window runs out first, the block enters stand-alone operation and powers up on its own.

Power-up takes one of two paths, chosen by the anti-pop select bit. The fast path waits a fixed number of master-clock cycles and then enables audio. The anti-pop path clamps the outputs to ground for a number of frames. It then raises a 16-bit ramp code one step per frame up to full scale, and enables audio only when the ramp is complete. In control-port operation, setting the power-down bit again returns the block to its powered-down state at once. Reset returns it to its reset state from any point.

Top module: `dac_pwrup_seq`

## Requirements
- R1: While `rst_i` is 1, the outputs read state 0, `clamp_o`=1, `ramp_o`=0, `audio_en_o`=0 and `cp_mode_o`=0. On the first clock after `rst_i` falls, the state becomes 1 (wait).
- R2: A frame is a rising edge of `lrck_i` seen after the synchronizer. The wait lasts WAIT_FRAMES frames when `speed_i`=0, twice that when `speed_i`=1, and four times that when `speed_i` is 2 or 3.
- R3: If no `cp_en_wr_i` pulse arrives before the wait ends, `cp_mode_o` stays 0 and power-up starts with no further input. In this mode `pdn_i` has no effect, and a running block stays in state 6.
- R4: A one-cycle `cp_en_wr_i` pulse during the wait sets `cp_mode_o` to 1 and moves the block to state 2 (powered down). The block stays in state 2 while `pdn_i` is 1.
- R5: In control-port mode, state 2 with `pdn_i`=0 starts power-up on the next clock.
- R6: When `popg_i`=0 at the start of power-up, the block spends exactly DELAY_CYCLES clocks in state 3 (delay) and then enters state 6 (running).
- R7: When `popg_i`=1 at the start of power-up, the block enters state 4 (clamp). It holds `clamp_o`=1 and `ramp_o`=0 there for CLAMP_FRAMES frames.
- R8: State 5 (ramp) lasts RAMP_FRAMES frames. In it `clamp_o` is 0 and `ramp_o` never decreases. On entry to state 6, `ramp_o` is 16'hFFFF.
- R9: `audio_en_o` is 1 only in state 6. `clamp_o` is 0 only in states 5 and 6. `ramp_o` is 0 in every state other than 5 and 6.
- R10: In control-port mode, `pdn_i`=1 in any of states 3, 4, 5 or 6 returns the block to state 2 on the next clock, with `clamp_o`=1, `audio_en_o`=0 and `ramp_o`=0.
- R11: `rst_i`=1 in any state returns the block to state 0 and clears `cp_mode_o` on the next clock.
- R12: `state_o` uses this encoding: 0 reset, 1 wait, 2 powered down, 3 delay, 4 clamp, 5 ramp, 6 running. No other value appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_i | input | 1 | Synchronous active-high reset |
| lrck_i | input | 1 | Frame clock, asynchronous to clk_i |
| speed_i | input | 2 | Speed mode: 0 single, 1 double, 2/3 quad |
| cp_en_wr_i | input | 1 | One-cycle control-port enable write strobe |
| pdn_i | input | 1 | Software power-down bit |
| popg_i | input | 1 | Anti-pop sequence select |
| clamp_o | output | 1 | Output clamp to ground active |
| ramp_o | output | RAMP_W | Ramp level code toward the quiescent level |
| audio_en_o | output | 1 | Audio output enabled |
| cp_mode_o | output | 1 | 1 = control-port mode, 0 = stand-alone |
| state_o | output | 3 | Sequencer state code |

## Verification
Results tied to the master clock are due on fixed cycles. Reset, `cp_en_wr_i` and `pdn_i` act on the next clock, and the delay state lasts exactly DELAY_CYCLES clocks. The bench checks those counts exactly. Frame-based durations carry a few cycles of synchronizer and edge-detect latency, and the first frame can fall anywhere in the LRCK phase. For those, the scoreboard measures the time spent in each state and accepts a window of one frame around the expected frame count. A ramp that starts on a frame edge is held to plus or minus one cycle. The monitor pops one expected item on each state change. It compares the state, mode flag, clamp, audio enable and ramp code in the same sampled cycle.

// File: rtl/dac_pwrup_pkg.sv
package dac_pwrup_pkg;
  typedef enum logic [2:0] {
    ST_RESET = 3'd0,
    ST_WAIT  = 3'd1,
    ST_PDN   = 3'd2,
    ST_DELAY = 3'd3,
    ST_CLAMP = 3'd4,
    ST_RAMP  = 3'd5,
    ST_RUN   = 3'd6
  } seq_state_e;
endpackage

// File: rtl/dac_lrck_edge.sv
// Brings the frame clock into the master domain and flags each rising edge.
module dac_lrck_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic lrck_i,
  output logic frame_tick_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i) begin
        if (rst_i) sync_q <= '0;
        else       sync_q <= lrck_i;
      end
    end else begin : g_many
      always_ff @(posedge clk_i) begin
        if (rst_i) sync_q <= '0;
        else       sync_q <= {sync_q[STAGES-2:0], lrck_i};
      end
    end
  endgenerate

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      last_q       <= 1'b0;
      frame_tick_o <= 1'b0;
    end else begin
      last_q       <= sync_q[STAGES-1];
      frame_tick_o <= sync_q[STAGES-1] & ~last_q;
    end
  end
endmodule

// File: rtl/dac_seq_fsm.sv
// Mode decision and power-up ordering, with one shared duration counter.
module dac_seq_fsm
  import dac_pwrup_pkg::*;
#(
  parameter int WAIT_FRAMES  = 512,
  parameter int CLAMP_FRAMES = 1000,
  parameter int RAMP_FRAMES  = 10000,
  parameter int DELAY_CYCLES = 12500
) (
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       tick_i,
  input  logic [1:0] speed_i,
  input  logic       cp_en_wr_i,
  input  logic       pdn_i,
  input  logic       popg_i,
  output seq_state_e cur_o,
  output seq_state_e nxt_o,
  output logic       clamp_o,
  output logic       audio_en_o,
  output logic       cp_mode_o
);
  localparam int MAX_AB = (4 * WAIT_FRAMES > CLAMP_FRAMES) ? 4 * WAIT_FRAMES : CLAMP_FRAMES;
  localparam int MAX_CD = (RAMP_FRAMES > DELAY_CYCLES) ? RAMP_FRAMES : DELAY_CYCLES;
  localparam int MAX_V  = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int CNT_W  = $clog2(MAX_V + 1);

  localparam logic [CNT_W-1:0] LIM_W1 = CNT_W'(WAIT_FRAMES - 1);
  localparam logic [CNT_W-1:0] LIM_W2 = CNT_W'(2 * WAIT_FRAMES - 1);
  localparam logic [CNT_W-1:0] LIM_W4 = CNT_W'(4 * WAIT_FRAMES - 1);
  localparam logic [CNT_W-1:0] LIM_C  = CNT_W'(CLAMP_FRAMES - 1);
  localparam logic [CNT_W-1:0] LIM_R  = CNT_W'(RAMP_FRAMES - 1);
  localparam logic [CNT_W-1:0] LIM_D  = CNT_W'(DELAY_CYCLES - 1);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] wait_lim;
  logic             cpm_q;
  logic             counting;
  seq_state_e       pwr_entry;

  always_comb begin
    case (speed_i)
      2'd0:    wait_lim = LIM_W1;
      2'd1:    wait_lim = LIM_W2;
      default: wait_lim = LIM_W4;
    endcase
  end

  assign pwr_entry = popg_i ? ST_CLAMP : ST_DELAY;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_RESET: state_d = ST_WAIT;
      ST_WAIT: begin
        if (cp_en_wr_i)                        state_d = ST_PDN;
        else if (tick_i && cnt_q == wait_lim)  state_d = pwr_entry;
      end
      ST_PDN:   if (!pdn_i)                    state_d = pwr_entry;
      ST_DELAY: if (cnt_q == LIM_D)            state_d = ST_RUN;
      ST_CLAMP: if (tick_i && cnt_q == LIM_C)  state_d = ST_RAMP;
      ST_RAMP:  if (tick_i && cnt_q == LIM_R)  state_d = ST_RUN;
      default:  state_d = state_q;
    endcase
    if (cpm_q && pdn_i &&
        (state_q == ST_DELAY || state_q == ST_CLAMP ||
         state_q == ST_RAMP  || state_q == ST_RUN))
      state_d = ST_PDN;
    if (rst_i) state_d = ST_RESET;
  end

  always_comb begin
    case (state_q)
      ST_WAIT, ST_CLAMP, ST_RAMP: counting = tick_i;
      ST_DELAY:                   counting = 1'b1;
      default:                    counting = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      state_q    <= ST_RESET;
      cnt_q      <= '0;
      cpm_q      <= 1'b0;
      clamp_o    <= 1'b1;
      audio_en_o <= 1'b0;
    end else begin
      state_q    <= state_d;
      if (state_d != state_q) cnt_q <= '0;
      else if (counting)      cnt_q <= cnt_q + 1'b1;
      if (state_q == ST_WAIT && cp_en_wr_i) cpm_q <= 1'b1;
      clamp_o    <= !(state_d == ST_RAMP || state_d == ST_RUN);
      audio_en_o <= (state_d == ST_RUN);
    end
  end

  assign cur_o     = state_q;
  assign nxt_o     = state_d;
  assign cp_mode_o = cpm_q;
endmodule

// File: rtl/dac_ramp_gen.sv
// Monotonic level code: one step per frame while ramping, full scale when running.
module dac_ramp_gen
  import dac_pwrup_pkg::*;
#(
  parameter int RAMP_W      = 16,
  parameter int RAMP_FRAMES = 10000
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  seq_state_e        cur_i,
  input  seq_state_e        nxt_i,
  input  logic              tick_i,
  output logic [RAMP_W-1:0] ramp_o
);
  localparam logic [RAMP_W-1:0] FULL = {RAMP_W{1'b1}};
  localparam logic [RAMP_W-1:0] STEP = RAMP_W'(FULL / RAMP_W'(RAMP_FRAMES));

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      ramp_o <= '0;
    end else begin
      case (nxt_i)
        ST_RUN:  ramp_o <= FULL;
        ST_RAMP: if (cur_i == ST_RAMP && tick_i) ramp_o <= ramp_o + STEP;
                 else if (cur_i != ST_RAMP)      ramp_o <= '0;
        default: ramp_o <= '0;
      endcase
    end
  end
endmodule

// File: rtl/dac_pwrup_seq.sv
module dac_pwrup_seq
  import dac_pwrup_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int WAIT_FRAMES  = 512,
  parameter int CLAMP_FRAMES = 1000,
  parameter int RAMP_FRAMES  = 10000,
  parameter int DELAY_CYCLES = 12500,
  parameter int RAMP_W       = 16
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              lrck_i,
  input  logic [1:0]        speed_i,
  input  logic              cp_en_wr_i,
  input  logic              pdn_i,
  input  logic              popg_i,
  output logic              clamp_o,
  output logic [RAMP_W-1:0] ramp_o,
  output logic              audio_en_o,
  output logic              cp_mode_o,
  output logic [2:0]        state_o
);
  logic       tick;
  seq_state_e cur_st, nxt_st;

  dac_lrck_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk_i(clk_i), .rst_i(rst_i), .lrck_i(lrck_i), .frame_tick_o(tick)
  );

  dac_seq_fsm #(
    .WAIT_FRAMES(WAIT_FRAMES), .CLAMP_FRAMES(CLAMP_FRAMES),
    .RAMP_FRAMES(RAMP_FRAMES), .DELAY_CYCLES(DELAY_CYCLES)
  ) u_fsm (
    .clk_i(clk_i), .rst_i(rst_i), .tick_i(tick), .speed_i(speed_i),
    .cp_en_wr_i(cp_en_wr_i), .pdn_i(pdn_i), .popg_i(popg_i),
    .cur_o(cur_st), .nxt_o(nxt_st), .clamp_o(clamp_o),
    .audio_en_o(audio_en_o), .cp_mode_o(cp_mode_o)
  );

  dac_ramp_gen #(.RAMP_W(RAMP_W), .RAMP_FRAMES(RAMP_FRAMES)) u_ramp (
    .clk_i(clk_i), .rst_i(rst_i), .cur_i(cur_st), .nxt_i(nxt_st),
    .tick_i(tick), .ramp_o(ramp_o)
  );

  assign state_o = cur_st;
endmodule

// File: rtl/dac_pwrup_chk.sv
module dac_pwrup_chk #(
  parameter int RAMP_W = 16
) (
  input logic              clk_i,
  input logic              rst_i,
  input logic              pdn_i,
  input logic              clamp_o,
  input logic [RAMP_W-1:0] ramp_o,
  input logic              audio_en_o,
  input logic              cp_mode_o,
  input logic [2:0]        state_o
);
  a_r1_reset_outputs: assert property (@(posedge clk_i)
    rst_i |=> (state_o == 3'd0 && clamp_o && !audio_en_o && ramp_o == '0 && !cp_mode_o));

  a_r1_release_to_wait: assert property (@(posedge clk_i) disable iff (rst_i)
    (state_o == 3'd0) |=> (state_o == 3'd1));

  a_r3_standalone_holds: assert property (@(posedge clk_i) disable iff (rst_i)
    (!cp_mode_o && state_o == 3'd6) |=> (state_o == 3'd6));

  a_r6_audio_entry: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(audio_en_o) |-> ($past(state_o) == 3'd3 || $past(state_o) == 3'd5));

  a_r8_ramp_monotonic: assert property (@(posedge clk_i) disable iff (rst_i)
    (state_o == 3'd5 && $past(state_o) == 3'd5) |-> (ramp_o >= $past(ramp_o)));

  a_r8_full_when_audio: assert property (@(posedge clk_i) disable iff (rst_i)
    audio_en_o |-> (ramp_o == {RAMP_W{1'b1}}));

  a_r9_audio_only_running: assert property (@(posedge clk_i) disable iff (rst_i)
    audio_en_o |-> (state_o == 3'd6 && !clamp_o));

  a_r10_pdn_return: assert property (@(posedge clk_i) disable iff (rst_i)
    (cp_mode_o && pdn_i && state_o >= 3'd3 && state_o <= 3'd6) |=> (state_o == 3'd2));

  a_r12_legal_code: assert property (@(posedge clk_i) disable iff (rst_i)
    state_o != 3'd7);
endmodule

bind dac_pwrup_seq dac_pwrup_chk #(.RAMP_W(RAMP_W)) u_chk (
  .clk_i(clk_i), .rst_i(rst_i), .pdn_i(pdn_i), .clamp_o(clamp_o),
  .ramp_o(ramp_o), .audio_en_o(audio_en_o), .cp_mode_o(cp_mode_o),
  .state_o(state_o)
);

// File: tb/test_dac_pwrup_seq.sv
module test_dac_pwrup_seq;
  localparam int W = 8, C = 5, R = 16, D = 12, P = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lrck = 1'b0;
  logic [1:0]  speed = 2'd0;
  logic        cp_wr = 1'b0;
  logic        pdn = 1'b1;
  logic        popg = 1'b0;
  logic        clamp, audio, cpm;
  logic [15:0] ramp;
  logic [2:0]  st;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [2:0] st;
    logic       cpm;
    int         lo;
    int         hi;
  } exp_t;
  exp_t sb_q[$];

  always #2 clk = ~clk;

  dac_pwrup_seq #(
    .WAIT_FRAMES(W), .CLAMP_FRAMES(C), .RAMP_FRAMES(R), .DELAY_CYCLES(D)
  ) i_dac_pwrup_seq (
    .clk_i(clk), .rst_i(rst), .lrck_i(lrck), .speed_i(speed),
    .cp_en_wr_i(cp_wr), .pdn_i(pdn), .popg_i(popg), .clamp_o(clamp),
    .ramp_o(ramp), .audio_en_o(audio), .cp_mode_o(cpm), .state_o(st)
  );

  initial forever begin
    repeat (P / 2) @(negedge clk);
    lrck = ~lrck;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [2:0] s, input logic m, input int lo, input int hi);
    exp_t e;
    e.st = s; e.cpm = m; e.lo = lo; e.hi = hi;
    sb_q.push_back(e);
  endtask

  function automatic int wait_frames(input logic [1:0] sp);
    return (sp == 2'd0) ? W : (sp == 2'd1) ? 2 * W : 4 * W;
  endfunction

  // Monitor: pops one expected item per state change (R9, R12 per item).
  logic [2:0]  prev_st;
  logic [15:0] prev_ramp;
  bit          mon_on = 0;
  int          elapsed = 0;
  int          cur_lo = -1, cur_hi = -1;
  logic [2:0]  cur_exp_st = 3'd0;

  always @(negedge clk) begin
    if (mon_on) begin
      elapsed++;
      if (st != prev_st) begin
        if (cur_lo >= 0)
          check(elapsed >= cur_lo && elapsed <= cur_hi, "R2/R6/R7/R8",
                $sformatf("cycles in state %0d (lo %0d hi %0d)", cur_exp_st, cur_lo, cur_hi),
                elapsed, cur_lo);
        if (sb_q.size() == 0) begin
          check(1'b0, "R12", "unexpected state change", st, prev_st);
          cur_lo = -1;
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          check(st == e.st, "R12", "state code", st, e.st);
          check(cpm == e.cpm, "R3/R4", "mode flag", cpm, e.cpm);
          check(audio == (e.st == 3'd6), "R9", "audio enable", audio, e.st == 3'd6);
          check(clamp == !(e.st == 3'd5 || e.st == 3'd6), "R9", "clamp", clamp,
                !(e.st == 3'd5 || e.st == 3'd6));
          if (e.st == 3'd6)
            check(ramp == 16'hFFFF, "R8", "ramp at run entry", ramp, 16'hFFFF);
          else if (e.st != 3'd5)
            check(ramp == 16'h0, "R7/R10", "ramp outside ramp state", ramp, 0);
          cur_lo = e.lo; cur_hi = e.hi; cur_exp_st = e.st;
        end
        elapsed = 0;
      end else if (st == 3'd5) begin
        check(ramp >= prev_ramp, "R8", "ramp monotonic", ramp, prev_ramp);
      end
      prev_st   = st;
      prev_ramp = ramp;
    end
  end

  task automatic drain(input string req);
    int n = 0;
    while (sb_q.size() != 0 && n < 5000) begin
      @(negedge clk);
      n++;
    end
    @(negedge clk);
    check(sb_q.size() == 0, req, "expected items left", sb_q.size(), 0);
  endtask

  task automatic reset_and_release(input logic [1:0] sp, input logic pg, input bit cp_path);
    push(3'd0, 1'b0, -1, -1);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(st == 3'd0 && !cpm && clamp && !audio, "R11", "reset from running/any state",
          st, 0);
    speed = sp; popg = pg;
    push(3'd1, 1'b0, cp_path ? -1 : (wait_frames(sp) - 1) * P,
                     cp_path ? -1 : wait_frames(sp) * P + P);
    rst = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    // R1 reset state at the ports
    check(st == 3'd0, "R1", "state in reset", st, 0);
    check(clamp == 1'b1 && audio == 1'b0, "R1", "clamp/audio in reset", {clamp, audio}, 2);
    check(ramp == 16'h0 && cpm == 1'b0, "R1", "ramp/mode in reset", ramp, 0);
    prev_st = st; prev_ramp = ramp; mon_on = 1;

    // R2 R3 R6: stand-alone, single speed, fast path
    speed = 2'd0; popg = 1'b0; pdn = 1'b1;
    push(3'd1, 1'b0, (W - 1) * P, W * P + P);
    push(3'd3, 1'b0, D, D);
    push(3'd6, 1'b0, -1, -1);
    rst = 1'b0;
    @(negedge clk);
    check(st == 3'd1, "R1", "wait one cycle after release", st, 1);
    drain("R3");
    // R3: pdn has no effect in stand-alone mode
    pdn = 1'b1; repeat (20) @(negedge clk);
    check(st == 3'd6 && audio, "R3", "pdn ignored stand-alone", st, 6);
    pdn = 1'b0; repeat (5) @(negedge clk);

    // R2 R7 R8: double speed, anti-pop path
    reset_and_release(2'd1, 1'b1, 1'b0);
    push(3'd4, 1'b0, (C - 1) * P, C * P + 1);
    push(3'd5, 1'b0, R * P - 1, R * P + 1);
    push(3'd6, 1'b0, -1, -1);
    drain("R8");
    check(ramp == 16'hFFFF, "R8", "ramp full while running", ramp, 16'hFFFF);

    // R2 quad speed, fast path
    reset_and_release(2'd2, 1'b0, 1'b0);
    push(3'd3, 1'b0, D, D);
    push(3'd6, 1'b0, -1, -1);
    drain("R2");

    // R4 R5 R10: control-port mode
    pdn = 1'b1;
    reset_and_release(2'd0, 1'b0, 1'b1);
    push(3'd2, 1'b1, -1, -1);
    repeat (20) @(negedge clk);
    cp_wr = 1'b1; @(negedge clk); cp_wr = 1'b0;
    drain("R4");
    repeat (100) @(negedge clk);
    check(st == 3'd2 && cpm, "R4", "held powered down while pdn=1", st, 2);
    push(3'd3, 1'b1, D, D);
    push(3'd6, 1'b1, -1, -1);
    pdn = 1'b0;
    drain("R5");
    push(3'd2, 1'b1, -1, -1);
    pdn = 1'b1;
    drain("R10");
    check(clamp && !audio && ramp == 16'h0, "R10", "powered down outputs", ramp, 0);
    popg = 1'b1;
    push(3'd4, 1'b1, (C - 1) * P, C * P + 1);
    push(3'd5, 1'b1, -1, -1);
    pdn = 1'b0;
    while (st != 3'd5) @(negedge clk);
    repeat (5 * P) @(negedge clk);
    push(3'd2, 1'b1, -1, -1);
    pdn = 1'b1;
    drain("R10");
    push(3'd4, 1'b1, (C - 1) * P, C * P + 1);
    push(3'd5, 1'b1, R * P - 1, R * P + 1);
    push(3'd6, 1'b1, -1, -1);
    pdn = 1'b0;
    drain("R7");

    // R11: reset from control-port running clears mode
    push(3'd0, 1'b0, -1, -1);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(st == 3'd0 && !cpm, "R11", "reset clears mode", cpm, 0);
    drain("R11");

    mon_on = 0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule